// File: doc/BRIEF.md
# Pipelined Bus T-State Tracker

This block follows the bus-cycle state of a processor that can overlap the address phase of one bus cycle with the data phase of the one before it. Each rising processor clock it samples the address strobe, the pipeline request, the cycle-done (ready) input and the hold grant. From these it keeps one of six states: idle, first state, second state, pipelined first state, pipelined second state, and hold.

Other chipset logic reads the tracker's outputs. It gets the current state as a one-hot vector and a flag that is high while the bus runs pipelined. It also gets a start strobe, which is high in either kind of first state, and a final strobe, which is high in the clock where a second state is being closed by ready.

Whether the next cycle is pipelined is decided by one thing: whether the address strobe came back before ready ended the current cycle. Once a cycle ends non-pipelined, the only way back into pipelining is a fresh T1 followed by a T2.

Top module: `tstate_tracker`

## Requirements
- R1: While `rst_ni` is low the state is TI. `state_o` is always exactly one-hot, with bit 0 = TI, bit 1 = T1, bit 2 = T2, bit 3 = T1P, bit 4 = T2P and bit 5 = TH. All transitions happen on the rising clock.
- R2: In TI, a high `bus_grant_i` moves to TH and has priority over the strobe. Otherwise a low `addr_strobe_ni` moves to T1, and with no strobe the state stays in TI. TH holds while `bus_grant_i` is high and goes to TI when it drops, whatever the strobe does.
- R3: T1 always goes to T2 in the next clock, whatever the other inputs are.
- R4: In T2 with `cycle_done_ni` high, the state moves to T2P only if `addr_strobe_ni` and `pipe_req_ni` are both low. Otherwise it stays in T2, so a strobe given while `pipe_req_ni` is high has no effect.
- R5: In T2 with `cycle_done_ni` low, a high `bus_grant_i` moves to TH. Otherwise a low `addr_strobe_ni` moves to T1, and otherwise the state goes to TI. It never goes to T1P.
- R6: In T2P with `cycle_done_ni` low, the next state is always T1P, whatever the grant or strobe. With `cycle_done_ni` high the state stays in T2P.
- R7: In T1P, `addr_strobe_ni` and `pipe_req_ni` both low move to T2P. Otherwise the state moves to T2.
- R8: T2P is entered only from T2, T1P or T2P, and T1P only from T2P. So after a cycle ends in T2, pipelining resumes only after passing through T1 and a T2.
- R9: `pipe_o` is high exactly in T1P and T2P. `start_o` is high exactly in T1 and T1P. `final_o` is high in the same clock in which the state is T2 or T2P and `cycle_done_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_strobe_ni | input | 1 | Address strobe, active low |
| pipe_req_ni | input | 1 | Pipeline request, active low |
| cycle_done_ni | input | 1 | Ready, ends the current cycle, active low |
| bus_grant_i | input | 1 | Hold grant, active high |
| state_o | output | 6 | One-hot T-state |
| pipe_o | output | 1 | Pipelined operation flag |
| start_o | output | 1 | Start-state strobe |
| final_o | output | 1 | Final-state strobe |

## Verification
The hardest situation to reach is a return to pipelining after a non-pipelined end. The stimulus first has to close a cycle in T2 with the pipeline request high, then restart through T1 and T2 with both requests low, and confirm that T2P appears only then. The bench also closes a cycle in T2 while the strobe is low and the pipeline request is active. It checks that this starts T1, not T1P, and it releases hold while a strobe is pending. The same-clock final strobe is sampled before the edge that consumes it.

// File: rtl/tstate_pkg.sv
package tstate_pkg;
  localparam int unsigned NUM_ST = 6;
  localparam int unsigned ST_TI  = 0;
  localparam int unsigned ST_T1  = 1;
  localparam int unsigned ST_T2  = 2;
  localparam int unsigned ST_T1P = 3;
  localparam int unsigned ST_T2P = 4;
  localparam int unsigned ST_TH  = 5;
  typedef logic [NUM_ST-1:0] st_vec_t;
endpackage

// File: rtl/tstate_next.sv
module tstate_next
  import tstate_pkg::*;
(
  input  st_vec_t cur_i,
  input  logic    strobe_i,
  input  logic    preq_i,
  input  logic    done_i,
  input  logic    grant_i,
  output st_vec_t nxt_o
);
  logic early_addr;
  assign early_addr = strobe_i & preq_i;

  always_comb begin
    nxt_o = '0;
    case (1'b1)
      cur_i[ST_TI]: begin
        if (grant_i)       nxt_o[ST_TH] = 1'b1;
        else if (strobe_i) nxt_o[ST_T1] = 1'b1;
        else               nxt_o[ST_TI] = 1'b1;
      end
      cur_i[ST_TH]: begin
        if (grant_i) nxt_o[ST_TH] = 1'b1;
        else         nxt_o[ST_TI] = 1'b1;
      end
      cur_i[ST_T1]: nxt_o[ST_T2] = 1'b1;
      cur_i[ST_T2]: begin
        if (done_i) begin
          // ready with strobe still pending: new cycle is non-pipelined
          if (grant_i)       nxt_o[ST_TH] = 1'b1;
          else if (strobe_i) nxt_o[ST_T1] = 1'b1;
          else               nxt_o[ST_TI] = 1'b1;
        end else if (early_addr) nxt_o[ST_T2P] = 1'b1;
        else                     nxt_o[ST_T2]  = 1'b1;
      end
      cur_i[ST_T2P]: begin
        if (done_i) nxt_o[ST_T1P] = 1'b1;
        else        nxt_o[ST_T2P] = 1'b1;
      end
      cur_i[ST_T1P]: begin
        if (early_addr) nxt_o[ST_T2P] = 1'b1;
        else            nxt_o[ST_T2]  = 1'b1;
      end
      default: nxt_o[ST_TI] = 1'b1;
    endcase
  end
endmodule

// File: rtl/tstate_reg.sv
module tstate_reg
  import tstate_pkg::*;
#(
  parameter int unsigned RST_IDX = ST_TI
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  st_vec_t d_i,
  output st_vec_t q_o
);
  localparam st_vec_t RST_VEC = st_vec_t'(1) << RST_IDX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VEC;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/tstate_decode.sv
module tstate_decode
  import tstate_pkg::*;
(
  input  st_vec_t st_i,
  input  logic    done_i,
  output logic    pipe_o,
  output logic    start_o,
  output logic    final_o
);
  assign pipe_o  = st_i[ST_T1P] | st_i[ST_T2P];
  assign start_o = st_i[ST_T1]  | st_i[ST_T1P];
  assign final_o = done_i & (st_i[ST_T2] | st_i[ST_T2P]);
endmodule

// File: rtl/tstate_tracker.sv
module tstate_tracker
  import tstate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_strobe_ni,
  input  logic              pipe_req_ni,
  input  logic              cycle_done_ni,
  input  logic              bus_grant_i,
  output logic [NUM_ST-1:0] state_o,
  output logic              pipe_o,
  output logic              start_o,
  output logic              final_o
);
  st_vec_t cur_q, nxt_d;
  logic    strobe, preq, done;

  assign strobe = ~addr_strobe_ni;
  assign preq   = ~pipe_req_ni;
  assign done   = ~cycle_done_ni;

  tstate_next u_next (
    .cur_i    (cur_q),
    .strobe_i (strobe),
    .preq_i   (preq),
    .done_i   (done),
    .grant_i  (bus_grant_i),
    .nxt_o    (nxt_d)
  );

  tstate_reg #(.RST_IDX(ST_TI)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nxt_d),
    .q_o    (cur_q)
  );

  tstate_decode u_dec (
    .st_i    (cur_q),
    .done_i  (done),
    .pipe_o  (pipe_o),
    .start_o (start_o),
    .final_o (final_o)
  );

  assign state_o = cur_q;
endmodule

// File: rtl/tstate_chk.sv
module tstate_chk
  import tstate_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_strobe_ni,
  input logic              pipe_req_ni,
  input logic              cycle_done_ni,
  input logic              bus_grant_i,
  input logic [NUM_ST-1:0] state_o,
  input logic              pipe_o,
  input logic              start_o,
  input logic              final_o
);
  assert_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_o) == 1);

  assert_idle_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[ST_TI] && bus_grant_i |=> state_o[ST_TH]);

  assert_t1_to_t2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[ST_T1] |=> state_o[ST_T2]);

  assert_no_pipe_without_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[ST_T2] && cycle_done_ni && pipe_req_ni |=> state_o[ST_T2]);

  assert_t2_end_not_t1p_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[ST_T2] && !cycle_done_ni |=> !state_o[ST_T1P]);

  assert_t2p_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[ST_T2P] && !cycle_done_ni |=> state_o[ST_T1P]);

  assert_t1p_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[ST_T1P] |=> (state_o[ST_T2] || state_o[ST_T2P]));

  assert_t2p_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[ST_T2P] |-> $past(state_o[ST_T2] || state_o[ST_T1P] || state_o[ST_T2P]));

  assert_t1p_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[ST_T1P] |-> $past(state_o[ST_T2P]));

  assert_strobes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_o == (state_o[ST_T1P] || state_o[ST_T2P])) &&
    (start_o == (state_o[ST_T1] || state_o[ST_T1P])));
endmodule

bind tstate_tracker tstate_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_strobe_ni (addr_strobe_ni),
  .pipe_req_ni    (pipe_req_ni),
  .cycle_done_ni  (cycle_done_ni),
  .bus_grant_i    (bus_grant_i),
  .state_o        (state_o),
  .pipe_o         (pipe_o),
  .start_o        (start_o),
  .final_o        (final_o)
);

// File: tb/tb_tstate_tracker.sv
module tb_tstate_tracker;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [5:0] S_TI  = 6'b000001;
  localparam logic [5:0] S_T1  = 6'b000010;
  localparam logic [5:0] S_T2  = 6'b000100;
  localparam logic [5:0] S_T1P = 6'b001000;
  localparam logic [5:0] S_T2P = 6'b010000;
  localparam logic [5:0] S_TH  = 6'b100000;

  typedef struct {
    logic [5:0] st;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_n = 1'b1, preq_n = 1'b1, done_n = 1'b1, grant = 1'b0;
  logic [5:0] state;
  logic pipe, start, fin;
  int n_chk = 0, n_bad = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tstate_tracker dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .addr_strobe_ni (strobe_n),
    .pipe_req_ni    (preq_n),
    .cycle_done_ni  (done_n),
    .bus_grant_i    (grant),
    .state_o        (state),
    .pipe_o         (pipe),
    .start_o        (start),
    .final_o        (fin)
  );

  task automatic cmp(input logic [5:0] act, input logic [5:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // monitor: one item per edge after it is pushed
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(state, e.st, {e.req, " state"});
      cmp({5'b0, pipe},  {5'b0, (e.st == S_T1P) || (e.st == S_T2P)}, "R9 pipe");
      cmp({5'b0, start}, {5'b0, (e.st == S_T1)  || (e.st == S_T1P)}, "R9 start");
    end
  end

  // driver: inputs at negedge, final strobe checked in the same cycle
  task automatic step(input logic s, input logic p, input logic d, input logic g,
                      input logic [5:0] exp, input logic exp_fin, input string req);
    exp_t e;
    @(negedge clk);
    strobe_n = s; preq_n = p; done_n = d; grant = g;
    e.st = exp; e.req = req;
    q.push_back(e);
    #1;
    cmp({5'b0, fin}, {5'b0, exp_fin}, "R9 final");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp(state, S_TI, "R1 reset");
    rst_n = 1'b1;
    fork
      begin
        step(1,1,1,0, S_TI,  0, "R2 idle");
        step(0,1,1,0, S_T1,  0, "R2 strobe");
        step(1,1,0,1, S_T2,  0, "R3 t1 ignores inputs");
        step(0,1,1,0, S_T2,  0, "R4 strobe without req");
        step(1,1,0,0, S_TI,  1, "R5 end to idle");
        step(0,1,1,0, S_T1,  0, "R2 strobe");
        step(1,1,1,0, S_T2,  0, "R3");
        step(0,0,1,0, S_T2P, 0, "R4 enter pipe");
        step(0,0,1,0, S_T2P, 0, "R6 wait");
        step(1,1,0,1, S_T1P, 1, "R6 end ignores grant");
        step(0,0,1,0, S_T2P, 0, "R7 t1p pipe");
        step(1,1,0,0, S_T1P, 1, "R6 end");
        step(1,1,1,0, S_T2,  0, "R7 t1p no pipe");
        step(0,0,0,0, S_T1,  1, "R5 end with strobe");
        step(1,1,1,0, S_T2,  0, "R3");
        step(1,1,0,1, S_TH,  1, "R5 end to hold");
        step(0,1,1,1, S_TH,  0, "R2 hold");
        step(0,1,1,0, S_TI,  0, "R2 release");
        step(0,1,1,1, S_TH,  0, "R2 grant priority");
        step(1,1,1,0, S_TI,  0, "R2 release");
        // non-pipelined end, then back to pipelining via T1,T2
        step(0,1,1,0, S_T1,  0, "R8");
        step(0,1,1,0, S_T2,  0, "R8");
        step(1,1,0,0, S_TI,  1, "R8 end in t2");
        step(0,0,1,0, S_T1,  0, "R8 restart");
        step(0,0,1,0, S_T2,  0, "R8 t2 first");
        step(0,0,1,0, S_T2P, 0, "R8 pipe again");
        step(1,1,0,0, S_T1P, 1, "R8");
        step(1,1,1,0, S_T2,  0, "R8");
        step(1,1,0,0, S_TI,  1, "R8");
        repeat (3) @(negedge clk);
      end
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule